// File: doc/BRIEF.md
# Register-Indirect Jump-and-Link Execution Unit

This unit performs the execute step of a register-indirect jump-and-link instruction in a 64-bit RISC pipeline. Each cycle it may accept one instruction. An instruction arrives with these inputs:

- the PC of the instruction,
- a base register value,
- a second addend, which is either a register value or a 13-bit immediate,
- the destination register index,
- the address-mask mode bit.

One cycle later the unit presents its results together. These are the jump target, the link value for the destination register, the write enable and index, a redirect-valid strobe and a misaligned-address trap flag. Because all results appear in the same cycle, the instruction in the delay slot can forward the link value straight away.

The link value is the PC of the jump itself. In address-mask mode its upper half is cleared. A target whose two low bits are not both zero raises the trap. The trap cancels the register write and the redirect. It also leaves the update enables for the data fault status register and the data fault address register low. Destination index zero turns the instruction into a plain jump, which is the usual subroutine return.

Top module: `jlink_exec`

## Requirements
- R1: While the synchronous active-high reset is high, and on the first cycle after it, every output is zero.
- R2: `out_valid` equals `in_valid` of the previous cycle. In a cycle where `out_valid` is 0, the outputs `wr_en`, `redirect` and `misalign_trap` are also 0.
- R3: `tgt_addr` equals `src_a` plus the second addend, taken modulo 2^64. The second addend is `src_b` when `use_imm` is 0. When `use_imm` is 1 it is `imm13` sign-extended from bit 12.
- R4: When `amask` is 0, `link_val` equals the `cur_pc` of the instruction.
- R5: When `amask` is 1, `link_val[63:32]` is 0 and `link_val[31:0]` equals `cur_pc[31:0]`.
- R6: `misalign_trap` is 1 exactly when `out_valid` is 1 and `tgt_addr[1:0]` is not 2'b00.
- R7: When `misalign_trap` is 1, both `wr_en` and `redirect` are 0.
- R8: `fsr_upd_en` and `far_upd_en` stay 0, and this holds on a misaligned-address trap as well.
- R9: When the destination index is 0, `wr_en` is 0. `redirect` still follows the trap rule of R7.
- R10: `wr_idx` equals the destination index of the instruction. `wr_en` is 1 when the result is valid, there is no trap and the index is not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| cur_pc | input | 64 | PC of the jump instruction |
| src_a | input | 64 | Base register operand |
| src_b | input | 64 | Register operand used as the addend |
| use_imm | input | 1 | Selects the immediate as the addend |
| imm13 | input | 13 | Signed immediate |
| dst_idx | input | 5 | Destination register index |
| amask | input | 1 | Address-mask mode bit |
| out_valid | output | 1 | Results are valid |
| tgt_addr | output | 64 | Jump target |
| link_val | output | 64 | Value to write to the destination register |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | 5 | Register write index |
| redirect | output | 1 | Fetch redirect to `tgt_addr` is valid |
| misalign_trap | output | 1 | Misaligned-address trap |
| fsr_upd_en | output | 1 | Update enable for the data fault status register |
| far_upd_en | output | 1 | Update enable for the data fault address register |

## Verification
Two functions can fall in the same cycle: the trap on a misaligned target and the link write to a nonzero destination. The bench provokes this collision with random low target bits and random nonzero destinations, and with directed cases that also set address-mask mode. The collision is judged correct when the trap is raised and the write, the redirect and both fault-register update enables all stay low. The bench also confirms that the masked link value is still reported in that cycle.

// File: rtl/jlink_exec.sv
module jlink_exec #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 13,
  parameter int IDX_W = 5,
  parameter int AM_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  src_a,
  input  logic [XLEN-1:0]  src_b,
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm13,
  input  logic [IDX_W-1:0] dst_idx,
  input  logic             amask,
  output logic             out_valid,
  output logic [XLEN-1:0]  tgt_addr,
  output logic [XLEN-1:0]  link_val,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             redirect,
  output logic             misalign_trap,
  output logic             fsr_upd_en,
  output logic             far_upd_en
);
  localparam int HI_W = XLEN - AM_W;

  logic [XLEN-1:0] addend, sum, link_n;
  logic            mis_n;

  assign addend = use_imm ? {{(XLEN-IMM_W){imm13[IMM_W-1]}}, imm13} : src_b;
  assign sum    = src_a + addend;
  assign link_n = amask ? {{HI_W{1'b0}}, cur_pc[AM_W-1:0]} : cur_pc;
  assign mis_n  = |sum[1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      tgt_addr      <= '0;
      link_val      <= '0;
      wr_en         <= 1'b0;
      wr_idx        <= '0;
      redirect      <= 1'b0;
      misalign_trap <= 1'b0;
    end else begin
      out_valid     <= in_valid;
      misalign_trap <= in_valid && mis_n;
      redirect      <= in_valid && !mis_n;
      wr_en         <= in_valid && !mis_n && (dst_idx != '0);
      if (in_valid) begin
        tgt_addr <= sum;
        link_val <= link_n;
        wr_idx   <= dst_idx;
      end
    end
  end

  assign fsr_upd_en = 1'b0;
  assign far_upd_en = 1'b0;
endmodule

module jlink_exec_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [XLEN-1:0]  cur_pc,
  input logic             amask,
  input logic [IDX_W-1:0] dst_idx,
  input logic             out_valid,
  input logic [XLEN-1:0]  tgt_addr,
  input logic [XLEN-1:0]  link_val,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             redirect,
  input logic             misalign_trap,
  input logic             fsr_upd_en,
  input logic             far_upd_en
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_valid_lat_R2: assert property (@(posedge clk) disable iff (rst)
    armed |-> out_valid == $past(in_valid));
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !wr_en && !redirect && !misalign_trap);
  assert_link_pc_R4: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid) && !$past(amask) |-> link_val == $past(cur_pc));
  assert_amask_hi_R5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid) && $past(amask) |-> link_val[XLEN-1:32] == '0);
  assert_trap_cond_R6: assert property (@(posedge clk) disable iff (rst)
    misalign_trap == (out_valid && tgt_addr[1:0] != 2'b00));
  assert_trap_kill_R7: assert property (@(posedge clk) disable iff (rst)
    misalign_trap |-> !wr_en && !redirect);
  assert_fault_regs_R8: assert property (@(posedge clk) disable iff (rst)
    misalign_trap |-> !fsr_upd_en && !far_upd_en);
  assert_zero_dst_R9: assert property (@(posedge clk) disable iff (rst)
    wr_idx == '0 |-> !wr_en);
  assert_wr_idx_R10: assert property (@(posedge clk) disable iff (rst)
    armed && $past(in_valid) |-> wr_idx == $past(dst_idx));
endmodule

bind jlink_exec jlink_exec_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc), .amask(amask),
  .dst_idx(dst_idx), .out_valid(out_valid), .tgt_addr(tgt_addr),
  .link_val(link_val), .wr_en(wr_en), .wr_idx(wr_idx), .redirect(redirect),
  .misalign_trap(misalign_trap), .fsr_upd_en(fsr_upd_en), .far_upd_en(far_upd_en)
);

// File: tb/sim_jlink_exec.sv
`timescale 1ns/1ps
module sim_jlink_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] cur_pc = '0, src_a = '0, src_b = '0;
  logic        use_imm = 1'b0;
  logic [12:0] imm13 = '0;
  logic [4:0]  dst_idx = '0;
  logic        amask = 1'b0;
  logic        out_valid, wr_en, redirect, misalign_trap, fsr_upd_en, far_upd_en;
  logic [63:0] tgt_addr, link_val;
  logic [4:0]  wr_idx;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  jlink_exec u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .cur_pc(cur_pc),
    .src_a(src_a), .src_b(src_b), .use_imm(use_imm), .imm13(imm13),
    .dst_idx(dst_idx), .amask(amask), .out_valid(out_valid), .tgt_addr(tgt_addr),
    .link_val(link_val), .wr_en(wr_en), .wr_idx(wr_idx), .redirect(redirect),
    .misalign_trap(misalign_trap), .fsr_upd_en(fsr_upd_en), .far_upd_en(far_upd_en));

  function automatic logic [63:0] f_tgt(logic [63:0] a, logic [63:0] b, logic ui, logic [12:0] im);
    logic [63:0] s;
    s = {{51{im[12]}}, im};
    return a + (ui ? s : b);
  endfunction

  function automatic logic [63:0] f_link(logic [63:0] pc, logic am);
    return am ? {32'h0, pc[31:0]} : pc;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [63:0] pc, logic [63:0] a, logic [63:0] b, logic ui,
                       logic [12:0] im, logic [4:0] d, logic am);
    logic [63:0] t;
    logic mis;
    @(negedge clk);
    in_valid = 1'b1; cur_pc = pc; src_a = a; src_b = b; use_imm = ui;
    imm13 = im; dst_idx = d; amask = am;
    @(posedge clk); #1;
    in_valid = 1'b0;
    t = f_tgt(a, b, ui, im);
    mis = |t[1:0];
    chk("R2 out_valid", {63'h0, out_valid}, 64'h1);
    chk("R3 tgt_addr", tgt_addr, t);
    chk(am ? "R5 link_val" : "R4 link_val", link_val, f_link(pc, am));
    chk("R6 misalign_trap", {63'h0, misalign_trap}, {63'h0, mis});
    chk("R7 redirect", {63'h0, redirect}, {63'h0, !mis});
    chk("R9/R10 wr_en", {63'h0, wr_en}, {63'h0, !mis && d != 0});
    chk("R10 wr_idx", {59'h0, wr_idx}, {59'h0, d});
    chk("R8 fault enables", {62'h0, fsr_upd_en, far_upd_en}, 64'h0);
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2 idle", {60'h0, out_valid, wr_en, redirect, misalign_trap}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", {out_valid, wr_en, redirect, misalign_trap, fsr_upd_en, far_upd_en,
                     wr_idx, tgt_addr[52:0]}, 64'h0);
    chk("R1 reset link", link_val, 64'h0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 after reset", {61'h0, out_valid, wr_en, redirect}, 64'h0);

    issue(64'hFFFF_FFFF_1234_5678, 64'h1000, 64'h20, 1'b0, 13'h0, 5'd15, 1'b0);
    issue(64'hFFFF_FFFF_1234_5678, 64'h1000, 64'h20, 1'b0, 13'h0, 5'd15, 1'b1);
    issue(64'h8000_0000_0000_0040, 64'h1008, 64'h0, 1'b1, 13'h1FF8, 5'd0, 1'b0);
    issue(64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFC, 64'h8, 1'b0, 13'h0, 5'd31, 1'b1);
    issue(64'hDEAD_BEEF_0000_0100, 64'h2000, 64'h0, 1'b1, 13'h0002, 5'd15, 1'b1);
    issue(64'h0000_0001_0000_0200, 64'h3001, 64'h0, 1'b0, 13'h0, 5'd0, 1'b0);
    issue(64'h10, 64'h0, 64'h0, 1'b1, 13'h1000, 5'd7, 1'b0);
    issue(64'h14, 64'h3, 64'h0, 1'b1, 13'h0FFF, 5'd9, 1'b0);
    idle_check();

    for (int i = 0; i < 400; i++) begin
      logic [63:0] pc, a, b;
      pc = {$urandom, $urandom};
      a  = {$urandom, $urandom};
      b  = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) b[1:0] = 2'b00 - a[1:0];
      issue(pc, a, b, 1'($urandom_range(0, 1)), 13'($urandom),
            5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 7) == 0) idle_check();
    end
    idle_check();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule